// File: doc/BRIEF.md
# Trap Entry and Return Frame Sequencer

This block carries out the hardware part of entering a trap or interrupt handler and of leaving it again. When a trap request arrives with a vector number, the sequencer fetches a two-word gate from a table in memory, located from a base address supplied by a table register input. It then compares the interrupted privilege level against the privilege level carried by the gate. If entry is permitted, it switches to the kernel stack given by the task-state inputs and writes the interrupted context there as five words. Finally it loads the new register set: code selector and handler address from the gate, kernel stack, privilege level zero, and flags with interrupts masked.

A return request reverses this. The sequencer pops five words starting at the current stack pointer and presents the restored context on its outputs. The surrounding core samples the interrupted context inputs when a request is accepted, and it takes the new context from the outputs in the cycle that `done` is high. Memory is a single word port with one cycle of read latency.

Top module: `trap_frame_seq`

## Requirements
- R1: While reset is high and after it is released, `busy`, `done` and `fault` are low and every context output is zero.
- R2: For vector v, the gate is read as two words: the handler address at `idt_base + 8*v`, then a control word at `idt_base + 8*v + 4`. Bits [15:0] of the control word hold the code selector and bits [17:16] hold the gate privilege level. Both reads come before any write.
- R3: Entry is allowed only when the interrupted privilege level is less than or equal to the gate level. Otherwise `fault` and `done` pulse together, nothing is written and the context outputs keep their values.
- R4: An allowed entry writes five words at `tss_sp-4`, `-8`, `-12`, `-16` and `-20`. In that order they are the old stack selector, the old stack pointer, the old flags, the old code selector and the old instruction pointer. Selectors are zero-extended to a word.
- R5: After an entry, the outputs are: stack selector and pointer `tss_ss` and `tss_sp-20`, flags equal to the old flags with bit 9 (interrupt enable) cleared, selector and handler address from the gate, and privilege level 0.
- R6: `busy` rises in the cycle after a request is accepted and stays high until the final output load. That is 8 cycles for an entry, 3 for a refused entry and 10 for a return. `done` then stays high for exactly one cycle.
- R7: A return reads five words upward from `cur_sp`: instruction pointer, code selector, flags, stack pointer, stack selector. All five are restored unmodified, including bit 9 of the flags. The privilege level output becomes bits [1:0] of the restored code selector.
- R8: Requests that arrive while `busy` is high are ignored. A trap request wins over a return request raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Start a handler entry |
| trap_vec | input | VEC_W | Vector number of the trap |
| ret_req | input | 1 | Start a return from handler |
| idt_base | input | DW | Base address of the gate table |
| tss_ss | input | SEL_W | Kernel stack selector from the task-state record |
| tss_sp | input | DW | Kernel stack pointer from the task-state record |
| cur_cpl | input | PL_W | Interrupted privilege level |
| cur_cs | input | SEL_W | Interrupted code selector |
| cur_ip | input | DW | Interrupted instruction pointer |
| cur_flags | input | DW | Interrupted flags |
| cur_ss | input | SEL_W | Interrupted stack selector |
| cur_sp | input | DW | Interrupted stack pointer (frame pointer on return) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | DW | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after the read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Protection fault, pulses with done |
| out_cpl | output | PL_W | New privilege level |
| out_cs | output | SEL_W | New code selector |
| out_ip | output | DW | New instruction pointer |
| out_flags | output | DW | New flags |
| out_ss | output | SEL_W | New stack selector |
| out_sp | output | DW | New stack pointer |

## Verification
The bench builds the block with its defaults: 32-bit words, 8-bit vectors, 16-bit selectors, 2-bit privilege levels and the interrupt-enable bit at position 9. An 8-bit vector lets the top gate slot at offset 0x7F8 be reached. Two privilege bits make the equal-level boundary and a refused user-to-kernel gate both reachable. The word-sized frames let the bench replay an entry's own pushed frame through a later return.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_RD1,
    ST_CHK,
    ST_PUSH,
    ST_POPA,
    ST_POPD
  } seq_st_e;
endpackage

// File: rtl/trap_gate_check.sv
module trap_gate_check #(
  parameter int SEL_W = 16,
  parameter int PL_W  = 2
) (
  input  logic [SEL_W+PL_W-1:0] gate_bits,
  input  logic [PL_W-1:0]       cpl,
  output logic [SEL_W-1:0]      sel,
  output logic                  allow
);
  logic [PL_W-1:0] dpl;

  always_comb begin
    sel   = gate_bits[SEL_W-1:0];
    dpl   = gate_bits[SEL_W +: PL_W];
    allow = (cpl <= dpl);
  end
endmodule

// File: rtl/trap_stack_ptr.sv
module trap_stack_ptr #(
  parameter int DW     = 32,
  parameter int WORD_B = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  input  logic          dec,
  input  logic          inc,
  output logic [DW-1:0] sp,
  output logic [DW-1:0] sp_dec
);
  localparam logic [DW-1:0] STEP = DW'(WORD_B);

  always_comb sp_dec = sp - STEP;

  always_ff @(posedge clk) begin
    if (rst)      sp <= '0;
    else if (ld)  sp <= ld_val;
    else if (dec) sp <= sp_dec;
    else if (inc) sp <= sp + STEP;
  end

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    (dec && !ld) |=> (sp == $past(sp) - STEP)); // R4
  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && !dec) |=> (sp == $past(sp) + STEP)); // R7
endmodule

// File: rtl/trap_frame_seq.sv
module trap_frame_seq
  import trap_seq_pkg::*;
#(
  parameter int DW     = 32,
  parameter int VEC_W  = 8,
  parameter int SEL_W  = 16,
  parameter int PL_W   = 2,
  parameter int IF_BIT = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trap_req,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic             ret_req,
  input  logic [DW-1:0]    idt_base,
  input  logic [SEL_W-1:0] tss_ss,
  input  logic [DW-1:0]    tss_sp,
  input  logic [PL_W-1:0]  cur_cpl,
  input  logic [SEL_W-1:0] cur_cs,
  input  logic [DW-1:0]    cur_ip,
  input  logic [DW-1:0]    cur_flags,
  input  logic [SEL_W-1:0] cur_ss,
  input  logic [DW-1:0]    cur_sp,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [PL_W-1:0]  out_cpl,
  output logic [SEL_W-1:0] out_cs,
  output logic [DW-1:0]    out_ip,
  output logic [DW-1:0]    out_flags,
  output logic [SEL_W-1:0] out_ss,
  output logic [DW-1:0]    out_sp
);
  localparam int WORD_B   = DW / 8;
  localparam int GATE_SH  = $clog2(2 * WORD_B);
  localparam int FRAME_N  = 5;
  localparam int K_W      = $clog2(FRAME_N);
  localparam logic [K_W-1:0] K_LAST = K_W'(FRAME_N - 1);
  localparam logic [DW-1:0] IF_MASK = DW'(1) << IF_BIT;

  seq_st_e         st;
  logic [K_W-1:0]  k;
  logic            op_ret;
  logic [PL_W-1:0] ctx_cpl;
  logic [SEL_W-1:0] ctx_cs, ctx_ss, kss, gate_sel;
  logic [DW-1:0]   ctx_ip, ctx_flags, ctx_sp, gate_addr, gate_ip;
  logic [DW-1:0]   frame [FRAME_N-1];

  logic [SEL_W-1:0] chk_sel;
  logic             chk_allow;
  logic             sp_ld, sp_dec_en, sp_inc_en;
  logic [DW-1:0]    sp_ld_val, sp, sp_dec;
  logic             take_trap, take_ret;

  trap_gate_check #(.SEL_W(SEL_W), .PL_W(PL_W)) u_gate (
    .gate_bits (mem_rdata[SEL_W+PL_W-1:0]),
    .cpl       (ctx_cpl),
    .sel       (chk_sel),
    .allow     (chk_allow)
  );

  always_comb begin
    take_trap = (st == ST_IDLE) && trap_req;
    take_ret  = (st == ST_IDLE) && !trap_req && ret_req;
    sp_ld     = take_ret || ((st == ST_CHK) && chk_allow);
    sp_ld_val = take_ret ? cur_sp : tss_sp;
    sp_dec_en = (st == ST_PUSH);
    sp_inc_en = (st == ST_POPD);
  end

  trap_stack_ptr #(.DW(DW), .WORD_B(WORD_B)) u_sp (
    .clk    (clk),
    .rst    (rst),
    .ld     (sp_ld),
    .ld_val (sp_ld_val),
    .dec    (sp_dec_en),
    .inc    (sp_inc_en),
    .sp     (sp),
    .sp_dec (sp_dec)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      ST_RD0:  begin mem_req = 1'b1; mem_addr = gate_addr; end
      ST_RD1:  begin mem_req = 1'b1; mem_addr = gate_addr + DW'(WORD_B); end
      ST_POPA: begin mem_req = 1'b1; mem_addr = sp; end
      ST_PUSH: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = sp_dec;
        case (k)
          3'd0:    mem_wdata = DW'(ctx_ss);
          3'd1:    mem_wdata = ctx_sp;
          3'd2:    mem_wdata = ctx_flags;
          3'd3:    mem_wdata = DW'(ctx_cs);
          default: mem_wdata = ctx_ip;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      k         <= '0;
      op_ret    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      fault     <= 1'b0;
      ctx_cpl   <= '0;
      ctx_cs    <= '0;
      ctx_ss    <= '0;
      ctx_ip    <= '0;
      ctx_flags <= '0;
      ctx_sp    <= '0;
      kss       <= '0;
      gate_sel  <= '0;
      gate_addr <= '0;
      gate_ip   <= '0;
      for (int i = 0; i < FRAME_N - 1; i++) frame[i] <= '0;
      out_cpl   <= '0;
      out_cs    <= '0;
      out_ip    <= '0;
      out_flags <= '0;
      out_ss    <= '0;
      out_sp    <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (take_trap) begin
            ctx_cpl   <= cur_cpl;
            ctx_cs    <= cur_cs;
            ctx_ss    <= cur_ss;
            ctx_ip    <= cur_ip;
            ctx_flags <= cur_flags;
            ctx_sp    <= cur_sp;
            gate_addr <= idt_base + (DW'(trap_vec) << GATE_SH);
            op_ret    <= 1'b0;
            busy      <= 1'b1;
            st        <= ST_RD0;
          end else if (take_ret) begin
            op_ret <= 1'b1;
            busy   <= 1'b1;
            k      <= '0;
            st     <= ST_POPA;
          end
        end
        ST_RD0: st <= ST_RD1;
        ST_RD1: begin
          gate_ip <= mem_rdata;
          st      <= ST_CHK;
        end
        ST_CHK: begin
          if (chk_allow) begin
            gate_sel <= chk_sel;
            kss      <= tss_ss;
            k        <= '0;
            st       <= ST_PUSH;
          end else begin
            fault <= 1'b1;
            done  <= 1'b1;
            busy  <= 1'b0;
            st    <= ST_IDLE;
          end
        end
        ST_PUSH: begin
          if (k == K_LAST) begin
            out_ss    <= kss;
            out_sp    <= sp_dec;
            out_flags <= ctx_flags & ~IF_MASK;
            out_cs    <= gate_sel;
            out_ip    <= gate_ip;
            out_cpl   <= '0;
            busy      <= 1'b0;
            done      <= 1'b1;
            st        <= ST_IDLE;
          end else begin
            k <= k + 1'b1;
          end
        end
        ST_POPA: st <= ST_POPD;
        ST_POPD: begin
          if (k == K_LAST) begin
            out_ip    <= frame[0];
            out_cs    <= frame[1][SEL_W-1:0];
            out_cpl   <= frame[1][PL_W-1:0];
            out_flags <= frame[2];
            out_sp    <= frame[3];
            out_ss    <= mem_rdata[SEL_W-1:0];
            busy      <= 1'b0;
            done      <= 1'b1;
            st        <= ST_IDLE;
          end else begin
            frame[k[1:0]] <= mem_rdata;
            k  <= k + 1'b1;
            st <= ST_POPA;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R6
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    fault |-> (done && !busy)); // R3
  AST_ENTRY_KERNEL: assert property (@(posedge clk) disable iff (rst)
    (done && !fault && !op_ret) |-> (out_cpl == '0 && !out_flags[IF_BIT])); // R5
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(out_ip) && $stable(out_sp) && $stable(out_cs))); // R8
endmodule

// File: tb/trap_frame_seq_bench.sv
module trap_frame_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trap_req = 1'b0;
  logic [7:0]  trap_vec = '0;
  logic        ret_req = 1'b0;
  logic [31:0] idt_base = 32'h0000_1000;
  logic [15:0] tss_ss = '0;
  logic [31:0] tss_sp = '0;
  logic [1:0]  cur_cpl = '0;
  logic [15:0] cur_cs = '0;
  logic [31:0] cur_ip = '0;
  logic [31:0] cur_flags = '0;
  logic [15:0] cur_ss = '0;
  logic [31:0] cur_sp = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        busy, done, fault;
  logic [1:0]  out_cpl;
  logic [15:0] out_cs, out_ss;
  logic [31:0] out_ip, out_flags, out_sp;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] wa[$];
  logic [31:0] wd[$];

  always #5 clk = ~clk;

  trap_frame_seq u_trap_frame_seq (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_vec(trap_vec),
    .ret_req(ret_req), .idt_base(idt_base), .tss_ss(tss_ss), .tss_sp(tss_sp),
    .cur_cpl(cur_cpl), .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_flags(cur_flags),
    .cur_ss(cur_ss), .cur_sp(cur_sp), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fault(fault), .out_cpl(out_cpl),
    .out_cs(out_cs), .out_ip(out_ip), .out_flags(out_flags),
    .out_ss(out_ss), .out_sp(out_sp)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wa.push_back(mem_addr);
        wd.push_back(mem_wdata);
      end else begin
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Compares busy/done/fault every cycle against the expected sequence length.
  task automatic run_seq(input bit t, input bit r, input int len, input bit exp_fault,
                         input logic [31:0] first_addr, input bit poke, input string tag);
    wa.delete();
    wd.delete();
    trap_req = t;
    ret_req  = r;
    @(negedge clk);
    trap_req = 1'b0;
    ret_req  = 1'b0;
    for (int i = 0; i < len; i++) begin
      chk({tag, " R6 busy high"}, {31'd0, busy}, 32'd1);
      chk({tag, " R6 done low while busy"}, {31'd0, done}, 32'd0);
      if (i == 0) begin
        chk({tag, " R2 first access is a read"}, {30'd0, mem_req, mem_we}, 32'd2);
        chk({tag, " R2 first address"}, mem_addr, first_addr);
      end
      if (poke && i == 1) begin
        trap_req = 1'b1;
        ret_req  = 1'b1;
      end
      if (poke && i == 2) begin
        trap_req = 1'b0;
        ret_req  = 1'b0;
      end
      @(negedge clk);
    end
    chk({tag, " R6 busy low at end"}, {31'd0, busy}, 32'd0);
    chk({tag, " R6 done pulse"}, {31'd0, done}, 32'd1);
    chk({tag, " R3 fault flag"}, {31'd0, fault}, {31'd0, exp_fault});
    @(negedge clk);
    chk({tag, " R6 done one cycle"}, {31'd0, done}, 32'd0);
    chk({tag, " R8 no restart from request during busy"}, {31'd0, busy}, 32'd0);
  endtask

  task automatic chk_pushes(input string tag, input logic [31:0] top,
                            input logic [31:0] e0, input logic [31:0] e1, input logic [31:0] e2,
                            input logic [31:0] e3, input logic [31:0] e4);
    logic [31:0] ev[5];
    ev = '{e0, e1, e2, e3, e4};
    chk({tag, " R4 push count"}, wa.size(), 32'd5);
    for (int i = 0; i < 5 && i < wa.size(); i++) begin
      chk({tag, " R4 push address"}, wa[i], top - 32'(4 * (i + 1)));
      chk({tag, " R4 push data"}, wd[i], ev[i]);
    end
  endtask

  task automatic chk_outs(input string tag, input logic [1:0] cpl, input logic [15:0] cs,
                          input logic [31:0] ip, input logic [31:0] fl,
                          input logic [15:0] ss, input logic [31:0] sp);
    chk({tag, " cpl"}, {30'd0, out_cpl}, {30'd0, cpl});
    chk({tag, " cs"}, {16'd0, out_cs}, {16'd0, cs});
    chk({tag, " ip"}, out_ip, ip);
    chk({tag, " flags"}, out_flags, fl);
    chk({tag, " ss"}, {16'd0, out_ss}, {16'd0, ss});
    chk({tag, " sp"}, out_sp, sp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Gate table: vec 3 allows level 3, vec 14 only level 0, vec 255 allows level 3.
    mem[32'h0000_1018] = 32'h0040_2000;
    mem[32'h0000_101C] = {14'd0, 2'd3, 16'h0008};
    mem[32'h0000_1070] = 32'h0060_0000;
    mem[32'h0000_1074] = {14'd0, 2'd0, 16'h0018};
    mem[32'h0000_17F8] = 32'h0050_0000;
    mem[32'h0000_17FC] = {14'd0, 2'd3, 16'h0030};

    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    chk("R1 done in reset", {31'd0, done}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 fault after reset", {31'd0, fault}, 32'd0);
    chk_outs("R1 reset outputs", 2'd0, 16'd0, 32'd0, 32'd0, 16'd0, 32'd0);

    // R2 R4 R5: user entry at the equal-level boundary with IF set.
    trap_vec = 8'd3; cur_cpl = 2'd3; cur_cs = 16'h001B; cur_ip = 32'h0800_0123;
    cur_flags = 32'h0000_0202; cur_ss = 16'h0023; cur_sp = 32'h7FFF_FF00;
    tss_ss = 16'h0010; tss_sp = 32'h0020_0000;
    run_seq(1'b1, 1'b0, 8, 1'b0, 32'h0000_1018, 1'b0, "entry vec3");
    chk_pushes("entry vec3", 32'h0020_0000, 32'h23, 32'h7FFF_FF00, 32'h202, 32'h1B, 32'h0800_0123);
    chk_outs("R5 entry vec3", 2'd0, 16'h0008, 32'h0040_2000, 32'h0000_0002, 16'h0010, 32'h001F_FFEC);

    // R3: user code into a level-0 gate is refused.
    trap_vec = 8'd14;
    run_seq(1'b1, 1'b0, 3, 1'b1, 32'h0000_1070, 1'b0, "refused vec14");
    chk("R3 refused entry writes nothing", wa.size(), 32'd0);
    chk_outs("R3 outputs held after fault", 2'd0, 16'h0008, 32'h0040_2000, 32'h0000_0002, 16'h0010, 32'h001F_FFEC);

    // R2 R8: top vector from kernel level, requests poked during busy.
    trap_vec = 8'd255; cur_cpl = 2'd0; cur_cs = 16'h0008; cur_ip = 32'h0010_0010;
    cur_flags = 32'h0000_0046; cur_ss = 16'h0010; cur_sp = 32'h001F_0000;
    tss_sp = 32'h0030_0000;
    run_seq(1'b1, 1'b0, 8, 1'b0, 32'h0000_17F8, 1'b1, "entry vec255");
    chk_pushes("entry vec255", 32'h0030_0000, 32'h10, 32'h001F_0000, 32'h46, 32'h08, 32'h0010_0010);
    chk_outs("R5 entry vec255", 2'd0, 16'h0030, 32'h0050_0000, 32'h0000_0046, 16'h0010, 32'h002F_FFEC);

    // R7: return through the frame pushed by the vec3 entry.
    cur_sp = 32'h001F_FFEC;
    run_seq(1'b0, 1'b1, 10, 1'b0, 32'h001F_FFEC, 1'b0, "return");
    chk("R7 return writes nothing", wa.size(), 32'd0);
    chk_outs("R7 restored context", 2'd3, 16'h001B, 32'h0800_0123, 32'h0000_0202, 16'h0023, 32'h7FFF_FF00);

    // R8: trap and return together, trap wins.
    trap_vec = 8'd3; cur_cpl = 2'd3; cur_cs = 16'h001B; cur_ip = 32'h0800_0200;
    cur_flags = 32'h0000_0200; cur_ss = 16'h0023; cur_sp = 32'h7FFF_FE00;
    tss_sp = 32'h0020_0000;
    run_seq(1'b1, 1'b1, 8, 1'b0, 32'h0000_1018, 1'b0, "R8 both requests");
    chk_pushes("R8 both requests", 32'h0020_0000, 32'h23, 32'h7FFF_FE00, 32'h200, 32'h1B, 32'h0800_0200);
    chk_outs("R8 trap taken", 2'd0, 16'h0008, 32'h0040_2000, 32'h0000_0000, 16'h0010, 32'h001F_FFEC);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule